// File: doc/BRIEF.md
# Multi-lane serial memory command front end

This block is the target side of a serial memory port. It oversamples the select line, the serial clock and four data lanes on the system clock. It decodes an 8-bit command, gathers a 24-bit address and counts dummy clocks. It then runs the data phase on one, two or four lanes. On the inside it drives a simple synchronous port into a 16-bit word array. That port takes a one-cycle read latency.

The protection logic and the power-state logic sit in neighbouring blocks. The front end asks the protection block for permission on every array word it writes, through `wr_allow_i`. It reads the status byte from `status_i`. It signals write-enable, write-disable and status-write requests as single-cycle pulses. Illegal commands and malformed writes raise a one-cycle `err_o` pulse.

The serial clock may idle low or idle high. The target samples input on a rising edge and drives output after a falling edge. The serial clock half period must be at least six system clock cycles.

Top module: `serial_mem_frontend`

## Requirements
- R1: After reset, `io_oe_o` is 0, and `mem_req_o`, `err_o`, `wren_o`, `wrdi_o` and `wrsr_o` are all low.
- R2: The command byte and the address are taken most significant bit first from lane 0 on rising serial clock edges. This works whether the serial clock idles low or idles high.
- R3: An unknown command byte raises one `err_o` pulse. Until select rises after it, no lane is driven and the array is not accessed.
- R4: Command 03h (read) has a 24-bit address, no dummy clocks and output on lane 1, most significant bit first. Byte address A maps to word A>>1, using bits 15:8 when A is even and bits 7:0 when A is odd.
- R5: Commands 0Bh, 3Bh and 6Bh (fast reads) insert 8 dummy clocks and then output on 1, 2 or 4 lanes. With two lanes, lane 1 carries the higher bit of each pair and `io_oe_o` is 0011b. With four lanes, lane 3 carries the highest bit and `io_oe_o` is 1111b. With one lane, `io_oe_o` is 0010b.
- R6: During a read, the byte address advances by one per byte. It wraps from the top of the 2^ADDR_W-byte array to zero, and the read continues until select rises.
- R7: Commands 02h, A2h and 32h write data on 1, 2 or 4 lanes, with the same bit order as R5. Each pair of bytes is written as one word, and the first byte of the pair goes to bits 15:8.
- R8: A write whose address has bit 0 set, or any command whose address has a nonzero bit at or above ADDR_W, raises `err_o` and is dropped. Such a write changes nothing in the array, and such a read drives no lane.
- R9: A write that ends with an odd byte count discards the unpaired last byte and raises `err_o` when select rises. Bytes beyond MAX_WR_BYTES are also discarded, with `err_o` raised when select rises.
- R10: An array word is written only when `wr_allow_i` is high as its second byte completes.
- R11: Command 05h returns `status_i`. Command 06h pulses `wren_o` and command 04h pulses `wrdi_o`, each when select rises. Command 01h pulses `wrsr_o` with `wrsr_data_o` holding the data byte, but only if select rises after exactly 8 data bits.
- R12: Command 9Fh returns three bytes: ID_MFR, ID_TYPE and ID_DENS, in that order.
- R13: `io_oe_o` returns to 0 no later than three system clock cycles after `cs_ni` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host |
| cs_ni | input | 1 | Active-low select |
| io_i | input | 4 | Data lanes as seen at the pads |
| io_o | output | 4 | Data lane output values |
| io_oe_o | output | 4 | Per-lane output enable |
| mem_req_o | output | 1 | Array access strobe |
| mem_we_o | output | 1 | Array write (with mem_req_o) |
| mem_addr_o | output | ADDR_W-1 | Array word address |
| mem_wdata_o | output | 16 | Array write word |
| mem_rdata_i | input | 16 | Array read word, valid one cycle after the request |
| wr_allow_i | input | 1 | Write permission from the protection block |
| status_i | input | 8 | Status byte from the protection block |
| wren_o | output | 1 | Write-enable request pulse |
| wrdi_o | output | 1 | Write-disable request pulse |
| wrsr_o | output | 1 | Status write request pulse |
| wrsr_data_o | output | 8 | Status byte to write |
| err_o | output | 1 | Command error pulse |

## Verification
Every input passes a two-stage synchronizer, so a serial edge takes effect about three system cycles later. Output lanes settle about four cycles after a falling edge, and a fetched byte is loaded five cycles after the rising edge that requests it. The bench therefore holds each serial clock level for eight system cycles and samples the lanes at the end of the low level, just before the next rising edge. Pulses from errors and from the enable and status-write requests are counted continuously and compared several cycles after select rises. Lane release is checked four cycles after select goes high.

// File: rtl/smf_pkg.sv
package smf_pkg;
  typedef enum logic [1:0] {LW1, LW2, LW4} lw_e;
  typedef enum logic [3:0] {K_BAD, K_WREN, K_WRDI, K_RDSR, K_WRSR,
                            K_WRITE, K_READ, K_FREAD, K_RDID} kind_e;
  typedef struct packed {
    kind_e kind;
    lw_e   lw;
  } cmd_t;
  typedef enum logic [2:0] {PH_OPC, PH_ADDR, PH_DUMMY, PH_DIN, PH_DOUT, PH_SINK} phase_e;

  function automatic logic [2:0] beat_last(lw_e lw);
    case (lw)
      LW2:     return 3'd3;
      LW4:     return 3'd1;
      default: return 3'd7;
    endcase
  endfunction

  function automatic logic [3:0] lane_mask(lw_e lw);
    case (lw)
      LW2:     return 4'b0011;
      LW4:     return 4'b1111;
      default: return 4'b0010;
    endcase
  endfunction
endpackage

// File: rtl/smf_sync.sv
module smf_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) st_q[k] <= RST_VAL;
    end else begin
      st_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) st_q[k] <= st_q[k-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/smf_decode.sv
module smf_decode
  import smf_pkg::*;
(
  input  logic [7:0] opc_i,
  output cmd_t       cmd_o
);
  always_comb begin
    cmd_o = '{kind: K_BAD, lw: LW1};
    case (opc_i)
      8'h06: cmd_o.kind = K_WREN;
      8'h04: cmd_o.kind = K_WRDI;
      8'h05: cmd_o.kind = K_RDSR;
      8'h01: cmd_o.kind = K_WRSR;
      8'h9F: cmd_o.kind = K_RDID;
      8'h02: cmd_o.kind = K_WRITE;
      8'hA2: cmd_o = '{kind: K_WRITE, lw: LW2};
      8'h32: cmd_o = '{kind: K_WRITE, lw: LW4};
      8'h03: cmd_o.kind = K_READ;
      8'h0B: cmd_o.kind = K_FREAD;
      8'h3B: cmd_o = '{kind: K_FREAD, lw: LW2};
      8'h6B: cmd_o = '{kind: K_FREAD, lw: LW4};
      default: cmd_o.kind = K_BAD;
    endcase
  end
endmodule

// File: rtl/smf_oshift.sv
module smf_oshift
  import smf_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] byte_i,
  input  logic       shift_i,
  input  lw_e        lw_i,
  output logic [3:0] io_o
);
  logic [7:0] sr_q;
  logic [3:0] io_q;
  logic [3:0] lanes;
  logic [7:0] sr_next;

  always_comb begin
    case (lw_i)
      LW2: begin lanes = {2'b00, sr_q[7:6]};      sr_next = {sr_q[5:0], 2'b00}; end
      LW4: begin lanes = sr_q[7:4];               sr_next = {sr_q[3:0], 4'b0000}; end
      default: begin lanes = {2'b00, sr_q[7], 1'b0}; sr_next = {sr_q[6:0], 1'b0}; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
      io_q <= '0;
    end else if (load_i) begin
      sr_q <= byte_i;
    end else if (shift_i) begin
      io_q <= lanes;
      sr_q <= sr_next;
    end
  end

  assign io_o = io_q;
endmodule

// File: rtl/serial_mem_frontend.sv
module serial_mem_frontend
  import smf_pkg::*;
#(
  parameter int         ADDR_W       = 20,
  parameter int         MAX_WR_BYTES = 2048,
  parameter int         SYNC_STAGES  = 2,
  parameter logic [7:0] ID_MFR       = 8'hE6,
  parameter logic [7:0] ID_TYPE      = 8'h4D,
  parameter logic [7:0] ID_DENS      = 8'h14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic [3:0]        io_i,
  output logic [3:0]        io_o,
  output logic [3:0]        io_oe_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-2:0] mem_addr_o,
  output logic [15:0]       mem_wdata_o,
  input  logic [15:0]       mem_rdata_i,
  input  logic              wr_allow_i,
  input  logic [7:0]        status_i,
  output logic              wren_o,
  output logic              wrdi_o,
  output logic              wrsr_o,
  output logic [7:0]        wrsr_data_o,
  output logic              err_o
);
  localparam int CNT_W = $clog2(MAX_WR_BYTES + 1);
  localparam logic [CNT_W-1:0] BCAP = CNT_W'(MAX_WR_BYTES);

  logic       cs_n_s, sclk_s, cs_q, sclk_q;
  logic [3:0] io_s;

  smf_sync #(.W(6), .STAGES(SYNC_STAGES), .RST_VAL(6'b100000)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i, io_i}),
    .q_o   ({cs_n_s, sclk_s, io_s})
  );

  logic rise, fall, cs_rise;
  assign rise    = sclk_s & ~sclk_q & ~cs_n_s;
  assign fall    = ~sclk_s & sclk_q & ~cs_n_s;
  assign cs_rise = cs_n_s & ~cs_q;

  phase_e            phase_q;
  cmd_t              cmd_q, dec_cmd;
  logic [22:0]       sh_q;
  logic [4:0]        cnt_q;
  logic [2:0]        beat_q;
  logic [CNT_W-1:0]  bcnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        in_sr_q, hi_q, din_next;
  logic [1:0]        id_idx_q;
  logic              over_q, opc_done_q, ld_q, ld2_q, drv_q;
  logic              we_q, err_q, wren_q, wrdi_q, wrsr_q;
  logic [ADDR_W-2:0] waddr_q;
  logic [15:0]       wdata_q;
  logic [7:0]        wrsr_d_q, ld_byte;
  logic [23:0]       addr_full;
  logic              beat_end, rd_array;

  assign addr_full = {sh_q, io_s[0]};
  assign beat_end  = (beat_q == beat_last(cmd_q.lw));
  assign rd_array  = (cmd_q.kind == K_READ) || (cmd_q.kind == K_FREAD);

  smf_decode u_dec (.opc_i({sh_q[6:0], io_s[0]}), .cmd_o(dec_cmd));

  always_comb begin
    case (cmd_q.lw)
      LW2:     din_next = {in_sr_q[5:0], io_s[1:0]};
      LW4:     din_next = {in_sr_q[3:0], io_s[3:0]};
      default: din_next = {in_sr_q[6:0], io_s[0]};
    endcase
  end

  always_comb begin
    case (cmd_q.kind)
      K_RDSR: ld_byte = status_i;
      K_RDID: begin
        case (id_idx_q)
          2'd0:    ld_byte = ID_MFR;
          2'd1:    ld_byte = ID_TYPE;
          2'd2:    ld_byte = ID_DENS;
          default: ld_byte = 8'h00;
        endcase
      end
      default: ld_byte = addr_q[0] ? mem_rdata_i[7:0] : mem_rdata_i[15:8];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
      phase_q <= PH_OPC;
      cmd_q <= '{kind: K_BAD, lw: LW1};
      sh_q <= '0; cnt_q <= '0; beat_q <= '0; bcnt_q <= '0; addr_q <= '0;
      in_sr_q <= '0; hi_q <= '0; id_idx_q <= '0;
      over_q <= 1'b0; opc_done_q <= 1'b0; ld_q <= 1'b0; ld2_q <= 1'b0; drv_q <= 1'b0;
      we_q <= 1'b0; err_q <= 1'b0; wren_q <= 1'b0; wrdi_q <= 1'b0; wrsr_q <= 1'b0;
      waddr_q <= '0; wdata_q <= '0; wrsr_d_q <= '0;
    end else begin
      cs_q   <= cs_n_s;
      sclk_q <= sclk_s;
      err_q <= 1'b0; wren_q <= 1'b0; wrdi_q <= 1'b0; wrsr_q <= 1'b0; we_q <= 1'b0;
      ld_q  <= 1'b0;
      ld2_q <= ld_q;
      if (cs_n_s) begin
        phase_q <= PH_OPC;
        cnt_q <= '0; beat_q <= '0; bcnt_q <= '0; id_idx_q <= '0;
        over_q <= 1'b0; opc_done_q <= 1'b0; drv_q <= 1'b0; ld2_q <= 1'b0;
        if (cs_rise && opc_done_q) begin
          case (cmd_q.kind)
            K_WREN:  wren_q <= 1'b1;
            K_WRDI:  wrdi_q <= 1'b1;
            K_WRSR:  if (phase_q == PH_DIN && bcnt_q == CNT_W'(1) && beat_q == '0) wrsr_q <= 1'b1;
            K_WRITE: if (phase_q == PH_DIN && (bcnt_q[0] || over_q)) err_q <= 1'b1;
            default: ;
          endcase
        end
      end else begin
        if (rise) begin
          case (phase_q)
            PH_OPC: begin
              sh_q  <= {sh_q[21:0], io_s[0]};
              cnt_q <= cnt_q + 5'd1;
              if (cnt_q == 5'd7) begin
                cmd_q <= dec_cmd;
                opc_done_q <= 1'b1;
                cnt_q <= '0;
                beat_q <= '0;
                case (dec_cmd.kind)
                  K_BAD:          begin phase_q <= PH_SINK; err_q <= 1'b1; end
                  K_WREN, K_WRDI: phase_q <= PH_SINK;
                  K_RDSR, K_RDID: begin phase_q <= PH_DOUT; ld_q <= 1'b1; end
                  K_WRSR:         phase_q <= PH_DIN;
                  default:        phase_q <= PH_ADDR;
                endcase
              end
            end
            PH_ADDR: begin
              sh_q  <= {sh_q[21:0], io_s[0]};
              cnt_q <= cnt_q + 5'd1;
              if (cnt_q == 5'd23) begin
                cnt_q <= '0;
                if ((|addr_full[23:ADDR_W]) || (cmd_q.kind == K_WRITE && addr_full[0])) begin
                  err_q   <= 1'b1;
                  phase_q <= PH_SINK;
                end else begin
                  addr_q <= addr_full[ADDR_W-1:0];
                  case (cmd_q.kind)
                    K_WRITE: phase_q <= PH_DIN;
                    K_READ:  begin phase_q <= PH_DOUT; ld_q <= 1'b1; end
                    default: phase_q <= PH_DUMMY;
                  endcase
                end
              end
            end
            PH_DUMMY: begin
              cnt_q <= cnt_q + 5'd1;
              if (cnt_q == 5'd7) begin
                cnt_q   <= '0;
                phase_q <= PH_DOUT;
                ld_q    <= 1'b1;
              end
            end
            PH_DIN: begin
              in_sr_q <= din_next;
              beat_q  <= beat_end ? 3'd0 : beat_q + 3'd1;
              if (beat_end) begin
                if (cmd_q.kind == K_WRSR) begin
                  if (bcnt_q == '0) wrsr_d_q <= din_next;
                  if (bcnt_q != BCAP) bcnt_q <= bcnt_q + 1'b1;
                end else if (bcnt_q == BCAP) begin
                  over_q <= 1'b1;
                end else begin
                  bcnt_q <= bcnt_q + 1'b1;
                  if (!bcnt_q[0]) begin
                    hi_q <= din_next;
                  end else begin
                    addr_q <= addr_q + ADDR_W'(2);
                    if (wr_allow_i) begin
                      we_q    <= 1'b1;
                      waddr_q <= addr_q[ADDR_W-1:1];
                      wdata_q <= {hi_q, din_next};
                    end
                  end
                end
              end
            end
            PH_DOUT: begin
              beat_q <= beat_end ? 3'd0 : beat_q + 3'd1;
              if (beat_end) ld_q <= 1'b1;
            end
            default: ;
          endcase
        end
        if (fall && phase_q == PH_DOUT) drv_q <= 1'b1;
        if (ld2_q) begin
          if (cmd_q.kind == K_RDID && id_idx_q != 2'd3) id_idx_q <= id_idx_q + 2'd1;
          if (rd_array) addr_q <= addr_q + 1'b1;
        end
      end
    end
  end

  smf_oshift u_osh (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ld2_q),
    .byte_i (ld_byte),
    .shift_i(fall && phase_q == PH_DOUT),
    .lw_i   (cmd_q.lw),
    .io_o   (io_o)
  );

  assign io_oe_o     = drv_q ? lane_mask(cmd_q.lw) : 4'b0000;
  assign mem_req_o   = we_q | (ld_q & rd_array);
  assign mem_we_o    = we_q;
  assign mem_addr_o  = we_q ? waddr_q : addr_q[ADDR_W-1:1];
  assign mem_wdata_o = wdata_q;
  assign wren_o      = wren_q;
  assign wrdi_o      = wrdi_q;
  assign wrsr_o      = wrsr_q;
  assign wrsr_data_o = wrsr_d_q;
  assign err_o       = err_q;

  AST_OE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_s |=> io_oe_o == 4'b0000); // R13
  AST_OE_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_oe_o == 4'b0000) || (io_oe_o == 4'b0010) || (io_oe_o == 4'b0011) || (io_oe_o == 4'b1111)); // R5
  AST_WE_PAIRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !bcnt_q[0] && cmd_q.kind == K_WRITE); // R7
  AST_WE_ALLOWED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(wr_allow_i)); // R10
  AST_READ_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld2_q && rd_array && !cs_n_s && (&addr_q)) |=> addr_q == '0); // R6
  AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o); // R3
  AST_NO_OE_SINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_SINK) |-> io_oe_o == 4'b0000 && !mem_req_o); // R8
endmodule

// File: tb/serial_mem_frontend_test.sv
module serial_mem_frontend_test;
  localparam int AW = 10;
  localparam int CAP = 8;
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic sclk = 1'b0, cs_n = 1'b1, wr_allow = 1'b1;
  logic [3:0] io_drv = '0, io_o, io_oe;
  logic mem_req, mem_we, wren, wrdi, wrsr, err;
  logic [AW-2:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [7:0] status = 8'h00, wrsr_data;

  serial_mem_frontend #(.ADDR_W(AW), .MAX_WR_BYTES(CAP)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .io_i(io_drv),
    .io_o(io_o), .io_oe_o(io_oe), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .wr_allow_i(wr_allow), .status_i(status), .wren_o(wren), .wrdi_o(wrdi),
    .wrsr_o(wrsr), .wrsr_data_o(wrsr_data), .err_o(err)
  );

  logic [15:0] bmem [512];
  always @(posedge clk) if (mem_req) begin
    if (mem_we) bmem[mem_addr] <= mem_wdata;
    else mem_rdata <= bmem[mem_addr];
  end

  int n_err = 0, n_wren = 0, n_wrdi = 0, n_wrsr = 0, n_req = 0;
  bit oe_seen = 0;
  always @(posedge clk) begin
    if (err) n_err++;
    if (wren) n_wren++;
    if (wrdi) n_wrdi++;
    if (wrsr) n_wrsr++;
    if (mem_req) n_req++;
    if (io_oe != 4'b0) oe_seen = 1;
  end

  int checks = 0, fails = 0;
  bit cpol = 0, oe_bad = 0, done = 0;
  logic [7:0] wb [16];
  logic [7:0] rb [16];

  function automatic logic [15:0] pat(int w);
    return 16'((w * 16'h0123) ^ 16'h5AA5);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic unit(input logic [3:0] d, output logic [3:0] q);
    sclk = 1'b0; io_drv = d;
    repeat (H) @(negedge clk);
    q = io_o;
    sclk = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  task automatic begin_x();
    sclk = cpol;
    repeat (4) @(negedge clk);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic end_x();
    if (!cpol) sclk = 1'b0;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, input int lanes);
    logic [7:0] v; logic [3:0] q;
    v = b;
    for (int k = 0; k < 8 / lanes; k++) begin
      unit(lanes == 1 ? {3'b0, v[7]} : lanes == 2 ? {2'b0, v[7:6]} : v[7:4], q);
      v = v << lanes;
    end
  endtask

  task automatic recv_byte(input int lanes, output logic [7:0] r);
    logic [3:0] q, m;
    m = lanes == 1 ? 4'b0010 : lanes == 2 ? 4'b0011 : 4'b1111;
    r = '0;
    for (int k = 0; k < 8 / lanes; k++) begin
      unit(4'b0, q);
      if (io_oe !== m) oe_bad = 1;
      r = lanes == 1 ? {r[6:0], q[1]} : lanes == 2 ? {r[5:0], q[1:0]} : {r[3:0], q};
    end
  endtask

  task automatic send_addr(input logic [23:0] a);
    send_byte(a[23:16], 1); send_byte(a[15:8], 1); send_byte(a[7:0], 1);
  endtask

  task automatic do_write(input logic [7:0] op, input int lanes, input logic [23:0] a, input int n);
    begin_x(); send_byte(op, 1); send_addr(a);
    for (int i = 0; i < n; i++) send_byte(wb[i], lanes);
    end_x();
  endtask

  task automatic do_read(input logic [7:0] op, input int lanes, input bit has_addr,
                         input logic [23:0] a, input int ndum, input int n);
    logic [3:0] q;
    begin_x(); send_byte(op, 1);
    if (has_addr) send_addr(a);
    for (int i = 0; i < ndum; i++) unit(4'b0, q);
    for (int i = 0; i < n; i++) recv_byte(lanes, rb[i]);
    end_x();
  endtask

  task automatic t_reset();
    chk("R1 oe", io_oe, 0); chk("R1 req", mem_req, 0); chk("R1 err", err, 0);
    chk("R1 pulses", {wren, wrdi, wrsr}, 0);
  endtask

  task automatic t_single();
    cpol = 0;
    wb[0] = 8'h11; wb[1] = 8'h22; wb[2] = 8'h33; wb[3] = 8'h44;
    do_write(8'h02, 1, 24'h000010, 4);
    chk("R7 R2 word0", bmem[8], 16'h1122); chk("R7 R2 word1", bmem[9], 16'h3344);
    cpol = 1;
    do_read(8'h03, 1, 1, 24'h000010, 0, 4);
    chk("R4 R2 rd", {rb[0], rb[1], rb[2], rb[3]}, 32'h11223344);
    do_read(8'h03, 1, 1, 24'h000011, 0, 2);
    chk("R4 odd start", {rb[0], rb[1]}, 32'h2233);
    cpol = 0;
  endtask

  task automatic t_multi();
    wb[0] = 8'h5A; wb[1] = 8'hC3; wb[2] = 8'h0F; wb[3] = 8'hE1;
    do_write(8'hA2, 2, 24'h000020, 4);
    chk("R7 dual", {bmem[16], bmem[17]}, 32'h5AC30FE1);
    wb[0] = 8'h9A; wb[1] = 8'hBC; wb[2] = 8'hDE; wb[3] = 8'hF0;
    do_write(8'h32, 4, 24'h000040, 4);
    chk("R7 quad", {bmem[32], bmem[33]}, 32'h9ABCDEF0);
    oe_bad = 0;
    do_read(8'h3B, 2, 1, 24'h000020, 8, 4);
    chk("R5 dual", {rb[0], rb[1], rb[2], rb[3]}, 32'h5AC30FE1);
    cpol = 1;
    do_read(8'h6B, 4, 1, 24'h000040, 8, 4);
    chk("R5 quad", {rb[0], rb[1], rb[2], rb[3]}, 32'h9ABCDEF0);
    cpol = 0;
    do_read(8'h0B, 1, 1, 24'h000012, 8, 2);
    chk("R5 single", {rb[0], rb[1]}, 32'h3344);
    chk("R5 oe lanes", oe_bad, 0);
  endtask

  task automatic t_wrap();
    do_read(8'h03, 1, 1, 24'h0003FF, 0, 3);
    chk("R6 wrap", {rb[0], rb[1], rb[2]}, {pat(511)[7:0], pat(0)});
  endtask

  task automatic t_bad();
    int e0;
    e0 = n_err;
    wb[0] = 8'h77; wb[1] = 8'h88;
    do_write(8'h02, 1, 24'h000031, 2);
    chk("R8 misaligned mem", bmem[24], pat(24));
    chk("R8 misaligned err", n_err - e0, 1);
    oe_seen = 0; e0 = n_err;
    do_read(8'h03, 1, 1, 24'h000400, 0, 1);
    chk("R8 upper err", n_err - e0, 1);
    chk("R8 upper no drive", oe_seen, 0);
  endtask

  task automatic t_len();
    int e0;
    e0 = n_err;
    wb[0] = 8'hA1; wb[1] = 8'hA2; wb[2] = 8'hA3;
    do_write(8'h02, 1, 24'h000050, 3);
    chk("R9 odd pair", bmem[40], 16'hA1A2);
    chk("R9 odd drop", bmem[41], pat(41));
    chk("R9 odd err", n_err - e0, 1);
    e0 = n_err;
    for (int i = 0; i < 10; i++) wb[i] = 8'(8'hB0 + i);
    do_write(8'h32, 4, 24'h000060, 10);
    chk("R9 cap last kept", bmem[51], 16'hB6B7);
    chk("R9 cap drop", bmem[52], pat(52));
    chk("R9 cap err", n_err - e0, 1);
  endtask

  task automatic t_allow();
    wr_allow = 1'b0;
    wb[0] = 8'hCC; wb[1] = 8'hDD;
    do_write(8'h02, 1, 24'h000070, 2);
    chk("R10 blocked", bmem[56], pat(56));
    wr_allow = 1'b1;
  endtask

  task automatic t_status();
    int c0; logic [3:0] q;
    status = 8'hA5;
    do_read(8'h05, 1, 0, 24'h0, 0, 1);
    chk("R11 status", rb[0], 8'hA5);
    c0 = n_wren;
    begin_x(); send_byte(8'h06, 1); end_x();
    chk("R11 wren", n_wren - c0, 1);
    c0 = n_wrdi;
    begin_x(); send_byte(8'h04, 1); end_x();
    chk("R11 wrdi", n_wrdi - c0, 1);
    c0 = n_wrsr;
    begin_x(); send_byte(8'h01, 1); send_byte(8'h3C, 1); end_x();
    chk("R11 wrsr", n_wrsr - c0, 1);
    chk("R11 wrsr data", wrsr_data, 8'h3C);
    c0 = n_wrsr;
    begin_x(); send_byte(8'h01, 1); send_byte(8'h3C, 1); unit(4'b0, q); end_x();
    chk("R11 wrsr extra bit", n_wrsr - c0, 0);
  endtask

  task automatic t_id();
    do_read(8'h9F, 1, 0, 24'h0, 0, 3);
    chk("R12 id", {rb[0], rb[1], rb[2]}, 32'hE64D14);
  endtask

  task automatic t_illegal();
    int e0, r0; logic [3:0] q;
    e0 = n_err; r0 = n_req; oe_seen = 0;
    begin_x(); send_byte(8'hFF, 1);
    for (int i = 0; i < 16; i++) unit(4'b0, q);
    end_x();
    chk("R3 err", n_err - e0, 1);
    chk("R3 no drive", oe_seen, 0);
    chk("R3 no access", n_req - r0, 0);
  endtask

  task automatic t_release();
    logic [3:0] q; logic [7:0] r;
    begin_x(); send_byte(8'h6B, 1); send_addr(24'h000040);
    for (int i = 0; i < 8; i++) unit(4'b0, q);
    recv_byte(4, r);
    unit(4'b0, q);
    chk("R13 oe before", io_oe, 4'b1111);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R13 released", io_oe, 4'b0000);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) bmem[i] = pat(i);
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_single();
    t_multi();
    t_wrap();
    t_bad();
    t_len();
    t_allow();
    t_status();
    t_id();
    t_illegal();
    t_release();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule